// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one parallel byte into an asynchronous serial frame. The frame shape comes from an 8-bit line-control word. The word selects how many data bits are sent (5 to 8) and whether a parity bit follows them. For parity it also selects even or odd sense. Last, it sets the length of the stop interval: one bit, two bits, or one and a half bits when characters are 5 bits long.

Bit timing comes from an external tick that pulses at 16 times the baud rate. The framer counts only the clock cycles in which that tick is high. This lets the stop interval end on a half-bit boundary.

A byte and its line-control word are handed over with a ready/valid handshake. Both are captured at acceptance, so the upstream logic may change them while the frame is still being sent. The serial output rests high between frames. A busy flag marks the frame in progress.

Top module: `uart_tx_framer`

## Requirements
- R1: Right after reset the serial output is high, busy is low and ready is high.
- R2: Line-control bits [1:0] select the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least significant first, and byte bits above the selected length are never sent.
- R3: A frame starts with a low start bit. The start bit and every data and parity bit last exactly 16 ticks, where a tick is a clock cycle with the tick input high while busy.
- R4: Line-control bit 3 set to 1 adds one parity bit after the data, and set to 0 sends none. Line-control bit 4 picks even parity when 1 and odd parity when 0. Parity is taken over the selected data bits only.
- R5: The stop interval is high. With line-control bit 2 at 0 it lasts 16 ticks. With bit 2 at 1 it lasts 32 ticks, or 24 ticks when bits [1:0] are 00.
- R6: A byte is accepted on a clock edge where valid and ready are both high. The data and line-control values present on that edge fully decide the frame, and later changes to those inputs have no effect on it.
- R7: Ready is high exactly when no frame is in progress. Busy goes high on the clock after acceptance and stays high until the stop interval ends.
- R8: The serial output is high whenever busy is low. While busy, it changes only on a clock edge where a tick ends a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | Framer can accept a byte (idle) |
| in_data | input | 8 | Byte to send |
| line_ctl | input | 8 | Frame format: [1:0] length, [2] stop, [3] parity enable, [4] even parity |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
The bench goes after the 5-bit two-stop setting, which must give a 24-tick stop interval. A design that misread it would end frames 8 ticks early or late. It also sends bytes with high bits set under short lengths, so a framer that leaked bit 5 or above into the frame or into the parity would give a wrong bit level. It checks odd and even parity on all-zero and all-one data, where an inverted sense flips the parity bit. After each acceptance it scrambles the data and line-control inputs, which exposes a framer that reads them live instead of capturing them. Ticks arrive at irregular intervals, so a framer that counts clocks instead of ticks shows the wrong bit length.

// File: rtl/uart_tx_pkg.sv
// Shared types for the UART transmit framer.
// Assumes: at most 8 data bits per character.
package uart_tx_pkg;

    // Phases of one serial frame.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } tx_phase_t;

    // Length of the stop interval.
    typedef enum logic [1:0] {
        STOP_ONE  = 2'd0,
        STOP_HALF = 2'd1,  // one and a half bits
        STOP_TWO  = 2'd2
    } stop_len_t;

    // Frame format decoded from a line-control word and its byte.
    typedef struct packed {
        logic [3:0] nbits;     // data bits, 5..8
        logic       par_en;    // a parity bit is sent
        logic       par_bit;   // level of that parity bit
        stop_len_t  stop_len;
    } frame_cfg_t;

endpackage

// File: rtl/uart_tx_cfg_decode.sv
// Decodes a line-control word and its byte into a frame format.
// Fields used: [1:0] length, [2] stop select, [3] parity enable, [4] even.
// Assumes: purely combinational; the caller registers the result.
module uart_tx_cfg_decode
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [7:0]        line_ctl,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg
);

    localparam int MIN_BITS = 5;

    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    // Build the mask of active data bits from the length field.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < MIN_BITS + int'(line_ctl[1:0]));
        end
    end

    // Parity is taken over the active data bits only.
    assign ones_odd = ^(data & mask);

    // Assemble the decoded format.
    always_comb begin
        cfg.nbits   = 4'(MIN_BITS) + {2'b00, line_ctl[1:0]};
        cfg.par_en  = line_ctl[3];
        cfg.par_bit = line_ctl[4] ? ones_odd : ~ones_odd;
        if (!line_ctl[2]) begin
            cfg.stop_len = STOP_ONE;
        end else if (line_ctl[1:0] == 2'b00) begin
            cfg.stop_len = STOP_HALF;
        end else begin
            cfg.stop_len = STOP_TWO;
        end
    end

endmodule

// File: rtl/uart_tx_bit_timer.sv
// Counts baud ticks inside one bit and flags the tick that ends it.
// Assumes: limit >= 1 and stable while a bit is timed; clear has priority.
module uart_tx_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);

    logic [CNT_W-1:0] cnt_q;

    assign bit_end = enable && tick && (cnt_q == limit - CNT_W'(1));

    // Tick counter, restarted at each bit end or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (bit_end) begin
            cnt_q <= '0;
        end else if (enable && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
// Serial transmit framer: start bit, LSB-first data, optional parity,
// stop interval with half-bit resolution.
// Assumes: tick16 is a one-cycle pulse at TICKS_PER_BIT times the baud
// rate; TICKS_PER_BIT is even so that half a bit is a whole tick count.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [7:0]        line_ctl,
    output logic              txd,
    output logic              busy
);

    localparam int MAX_TICKS = 2 * TICKS_PER_BIT;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] T_ONE  = CNT_W'(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CNT_W-1:0] T_TWO  = CNT_W'(MAX_TICKS);

    tx_phase_t         phase_q;
    frame_cfg_t        cfg_q;
    frame_cfg_t        cfg_next;
    logic [DATA_W-1:0] shift_q;
    logic [3:0]        left_q;
    logic [CNT_W-1:0]  limit;
    logic              accept;
    logic              bit_end;

    assign accept   = in_valid && in_ready;
    assign in_ready = (phase_q == PH_IDLE);
    assign busy     = (phase_q != PH_IDLE);

    uart_tx_cfg_decode #(.DATA_W(DATA_W)) i_decode (
        .line_ctl (line_ctl),
        .data     (in_data),
        .cfg      (cfg_next)
    );

    // Length of the current bit in ticks.
    always_comb begin
        limit = T_ONE;
        if (phase_q == PH_STOP) begin
            case (cfg_q.stop_len)
                STOP_HALF: limit = T_HALF;
                STOP_TWO:  limit = T_TWO;
                default:   limit = T_ONE;
            endcase
        end
    end

    uart_tx_bit_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .enable  (busy),
        .tick    (tick16),
        .limit   (limit),
        .bit_end (bit_end)
    );

    // Frame sequencer: captures the format and steps through the phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            shift_q <= '0;
            left_q  <= '0;
        end else if (accept) begin
            phase_q <= PH_START;
            cfg_q   <= cfg_next;
            shift_q <= in_data;
        end else if (bit_end) begin
            case (phase_q)
                PH_START: begin
                    phase_q <= PH_DATA;
                    left_q  <= cfg_q.nbits - 4'd1;
                end
                PH_DATA: begin
                    shift_q <= shift_q >> 1;
                    if (left_q == 4'd0) begin
                        phase_q <= cfg_q.par_en ? PH_PARITY : PH_STOP;
                    end else begin
                        left_q <= left_q - 4'd1;
                    end
                end
                PH_PARITY: phase_q <= PH_STOP;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Line level for the current phase.
    always_comb begin
        case (phase_q)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = shift_q[0];
            PH_PARITY: txd = cfg_q.par_bit;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer_chk.sv
// Protocol checker for the transmit framer, attached by bind.
// Assumes: sampled on the rising clock edge, synchronous active-low reset.
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic busy
);

    // R8: line rests high outside a frame.
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R3: a frame opens with the low start bit.
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R5: the frame closes out of a high stop interval.
    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));

    // R7: no acceptance while a frame is in progress.
    a_r7_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R7: an accepted byte starts a frame on the next cycle.
    a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R8: inside a frame the line moves only after a tick.
    a_r8_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick16)) |-> $stable(txd));

endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .busy     (busy)
);

// File: tb/test_uart_tx_framer.sv
// Self-checking bench: directed corners plus seeded random frames.
module test_uart_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] line_ctl = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    uart_tx_framer i_uart_tx_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .line_ctl (line_ctl),
        .txd      (txd),
        .busy     (busy)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Irregular baud ticks, driven just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1 tick16 = ($urandom_range(0, 1) == 1);
        end
    end

    function automatic int n_bits(logic [7:0] lc);
        return 5 + int'(lc[1:0]);
    endfunction

    function automatic logic par_of(logic [7:0] d, logic [7:0] lc);
        logic p = 1'b0;
        for (int i = 0; i < n_bits(lc); i++) p ^= d[i];
        return lc[4] ? p : ~p;
    endfunction

    function automatic int stop_ticks(logic [7:0] lc);
        if (!lc[2]) return 16;
        return (lc[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic int frame_ticks(logic [7:0] lc);
        return 16 * (1 + n_bits(lc) + int'(lc[3])) + stop_ticks(lc);
    endfunction

    function automatic logic level_at(logic [7:0] d, logic [7:0] lc, int t);
        int b;
        if (t < 16) return 1'b0;
        b = t / 16 - 1;
        if (b < n_bits(lc)) return d[b];
        if (lc[3] && b == n_bits(lc)) return par_of(d, lc);
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Send one frame and compare every tick-sampled line level.
    task automatic send_frame(logic [7:0] d, logic [7:0] lc, string req);
        int t = 0;
        int bad = 0;
        int bad_t = -1;
        int bad_act = 0;
        int bad_exp = 0;
        int rdy_bad = 0;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = d;
        line_ctl = lc;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        // R6: scramble inputs after acceptance.
        in_valid = 1'b0;
        in_data  = 8'($urandom);
        line_ctl = ~lc;
        forever begin
            @(negedge clk);
            if (!busy) break;
            if (in_ready) rdy_bad++;
            if (tick16) begin
                if (txd !== level_at(d, lc, t)) begin
                    if (bad == 0) begin
                        bad_t = t;
                        bad_act = int'(txd);
                        bad_exp = int'(level_at(d, lc, t));
                    end
                    bad++;
                end
                t++;
            end
        end
        check(bad == 0, req, $sformatf("level at tick %0d d=%h lc=%h", bad_t, d, lc),
              bad_act, bad_exp);
        check(t == frame_ticks(lc), "R5", $sformatf("frame ticks lc=%h", lc),
              t, frame_ticks(lc));
        check(rdy_bad == 0, "R7", "ready high while busy", rdy_bad, 0);
        check(txd === 1'b1, "R8", "idle level after frame", int'(txd), 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
        check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);

        // R2: every length, high bits set beyond short lengths.
        send_frame(8'hE5, 8'h00, "R2");
        send_frame(8'hC3, 8'h01, "R2");
        send_frame(8'hA9, 8'h02, "R2");
        send_frame(8'h5A, 8'h03, "R2");
        // R5: stop lengths, including the half-bit case.
        send_frame(8'h11, 8'h04, "R5");
        send_frame(8'h22, 8'h05, "R5");
        send_frame(8'h7F, 8'h07, "R5");
        // R4: parity sense on all-zero and all-one data, masked bits.
        send_frame(8'h00, 8'h18, "R4");
        send_frame(8'h00, 8'h08, "R4");
        send_frame(8'hFF, 8'h1B, "R4");
        send_frame(8'hFF, 8'h0B, "R4");
        send_frame(8'hE0, 8'h1C, "R4");
        // R3/R6: random frames with mid-frame input changes.
        for (int n = 0; n < 80; n++) begin
            send_frame(8'($urandom), {3'b000, 5'($urandom)}, "R3");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule